// File: doc/BRIEF.md
# Codec Shadow Register Writer

This block fronts a write-only audio codec whose control registers cannot be read back over its serial link. It keeps a shadow copy of every codec register, turns each host write into a two-byte command on a byte-wide valid/ready link, and answers register and volume queries from the shadow without any link traffic.

The host issues one request at a time while `busy` is low. There are four kinds of request: a plain register write that also updates the shadow, a write that only goes out on the link, and stereo volume updates for the DAC and for the ADC. A volume update takes a user step per channel (0 to 128, half a decibel per step) and converts it to an attenuation code. Only channels whose code actually moves are written. For DAC channels each cached write is followed by a second write of the same code with the update-latch bit set. Every accepted request gets a one-cycle response that flags whether anything was sent and whether the request was refused.

Top module: `codec_shadow_writer`

## Requirements
- R1: Each link command is the 16-bit word {index[6:0], value[8:0]}. The upper byte goes out first and the lower byte second.
- R2: A register request with index above 0x17, or with a 17-bit value whose bit 16 is set, is refused. A volume request with either step above 128 is also refused. A refused request sends no byte, leaves the shadow untouched and returns resp_rejected=1.
- R3: A cached write (req_op=0) stores the full 16-bit value in the shadow, and rd_data shows it. An uncached write (req_op=1) sends its command but leaves rd_data at the old value.
- R4: A volume step of 0 maps to code 0. Any other step s maps to s + (FS - 128), where FS is 0xFF for the DAC (req_op=2) and 0xCF for the ADC (req_op=3).
- R5: Volume read-back uses the low 8 shadow bits of each channel register. It returns code minus (FS - 128) when the code exceeds that offset, and 0 otherwise. rd_vol_sel=0 selects the DAC and 1 selects the ADC.
- R6: The left channel sits at the base index and the right channel at base+1. The DAC base is 0x03 and the ADC base is 0x0E. The left channel's commands always go out before the right channel's.
- R7: For each changed DAC channel, the block sends the cached command with the new code and then the same code with bit 8 set. The latch command does not alter the shadow. ADC channels get only the cached command.
- R8: A volume channel is written only when its new code differs from the low 8 shadow bits. resp_changed is 1 exactly when at least one command is sent. A request that changes nothing leaves busy low.
- R9: After reset every shadow register reads 0, and busy and tx_valid are low.
- R10: busy is high from the cycle after an accepted request that queues commands until its last byte is taken. A request presented while busy is high is ignored and gets no response.
- R11: A byte offered on tx_valid keeps tx_valid high and tx_data unchanged until tx_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request strobe, taken when busy is low |
| req_op | input | 2 | 0 cached write, 1 uncached write, 2 DAC volume, 3 ADC volume |
| req_index | input | 7 | Register index for write requests |
| req_value | input | 17 | Register value for write requests |
| req_vol_l | input | 8 | Left volume step |
| req_vol_r | input | 8 | Right volume step |
| busy | output | 1 | Commands pending or in flight |
| resp_valid | output | 1 | One-cycle response to an accepted request |
| resp_changed | output | 1 | At least one command was queued |
| resp_rejected | output | 1 | Request refused |
| rd_index | input | 7 | Shadow read index |
| rd_data | output | 16 | Shadow content, 0 for an index outside the file |
| rd_vol_sel | input | 1 | 0 DAC, 1 ADC volume read-back |
| rd_vol_l | output | 8 | Left volume step from shadow |
| rd_vol_r | output | 8 | Right volume step from shadow |
| tx_valid | output | 1 | Link byte valid |
| tx_data | output | 8 | Link byte |
| tx_ready | input | 1 | Link accepts byte |

## Verification
Two things can land on the same clock edge. The first is a host request and the acceptance of the final byte of the previous command train. The second is a shadow read-back and the cached write that changes it. The bench stalls the link on a fixed pattern so that requests are offered while bytes are still draining. It pulses a write during busy and then confirms through rd_data and the byte scoreboard that the write left no trace. Read-back is sampled on the cycle after acceptance, when the cached value must already show and the uncached one must not.

// File: rtl/csw_pkg.sv
package csw_pkg;

    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        OP_WRITE    = 2'd0,
        OP_WRITE_NC = 2'd1,
        OP_VOL_DAC  = 2'd2,
        OP_VOL_ADC  = 2'd3
    } op_e;

    // step 0 is the mute floor; otherwise shift into the codec code range
    function automatic logic [CODE_W-1:0] vol_to_code(
        input logic [CODE_W-1:0] step,
        input logic [CODE_W-1:0] offset
    );
        if (step == '0) return '0;
        return step + offset;
    endfunction

    function automatic logic [CODE_W-1:0] code_to_vol(
        input logic [CODE_W-1:0] code,
        input logic [CODE_W-1:0] offset
    );
        if (code > offset) return code - offset;
        return '0;
    endfunction

endpackage

// File: rtl/csw_shadow.sv
module csw_shadow #(
    parameter int NUM_REGS = 24,
    parameter int IDX_W    = 7,
    parameter int DATA_W   = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we_a,
    input  logic [IDX_W-1:0]                 idx_a,
    input  logic [DATA_W-1:0]                dat_a,
    input  logic                             we_b,
    input  logic [IDX_W-1:0]                 idx_b,
    input  logic [DATA_W-1:0]                dat_b,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

    logic [NUM_REGS-1:0][DATA_W-1:0] shadow_d, shadow_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_comb begin
            shadow_d[g] = shadow_q[g];
            if (we_a && idx_a == IDX_W'(g)) shadow_d[g] = dat_a;
            if (we_b && idx_b == IDX_W'(g)) shadow_d[g] = dat_b;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shadow_q[g] <= '0;
            else        shadow_q[g] <= shadow_d[g];
        end
    end

    assign regs_o = shadow_q;

endmodule

// File: rtl/csw_byte_tx.sv
module csw_byte_tx #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              word_ready_o,
    output logic              tx_valid_o,
    output logic [BYTE_W-1:0] tx_data_o,
    input  logic              tx_ready_i,
    output logic              busy_o
);

    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int LEFT_W = $clog2(NBYTES + 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [LEFT_W-1:0] left;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (tx_q.left == '0) begin
            if (word_valid_i) begin
                tx_d.word = word_i;
                tx_d.left = LEFT_W'(NBYTES);
            end
        end else if (tx_ready_i) begin
            tx_d.word = tx_q.word << BYTE_W;
            tx_d.left = tx_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign word_ready_o = (tx_q.left == '0);
    assign tx_valid_o   = (tx_q.left != '0);
    assign tx_data_o    = tx_q.word[WORD_W-1 -: BYTE_W];
    assign busy_o       = tx_valid_o;

endmodule

// File: rtl/csw_vol_read.sv
module csw_vol_read #(
    parameter int NCH    = 2,
    parameter int CODE_W = 8,
    parameter int DAC_OFF = 127,
    parameter int ADC_OFF = 79
) (
    input  logic [NCH-1:0][CODE_W-1:0] dac_codes_i,
    input  logic [NCH-1:0][CODE_W-1:0] adc_codes_i,
    input  logic                       sel_adc_i,
    output logic [NCH-1:0][CODE_W-1:0] vol_o
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_comb begin
            if (sel_adc_i) vol_o[ch] = csw_pkg::code_to_vol(adc_codes_i[ch], CODE_W'(ADC_OFF));
            else           vol_o[ch] = csw_pkg::code_to_vol(dac_codes_i[ch], CODE_W'(DAC_OFF));
        end
    end

endmodule

// File: rtl/codec_shadow_writer.sv
module codec_shadow_writer #(
    parameter int NUM_REGS  = 24,
    parameter int IDX_W     = 7,
    parameter int DATA_W    = 16,
    parameter int VAL_W     = 9,
    parameter int BYTE_W    = 8,
    parameter int QDEPTH    = 4,
    parameter int VOL_STEPS = 128,
    parameter int DAC_BASE  = 3,
    parameter int ADC_BASE  = 14,
    parameter int DAC_FS    = 255,
    parameter int ADC_FS    = 207
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [IDX_W-1:0]   req_index,
    input  logic [DATA_W:0]    req_value,
    input  logic [7:0]         req_vol_l,
    input  logic [7:0]         req_vol_r,
    output logic               busy,
    output logic               resp_valid,
    output logic               resp_changed,
    output logic               resp_rejected,
    input  logic [IDX_W-1:0]   rd_index,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               rd_vol_sel,
    output logic [7:0]         rd_vol_l,
    output logic [7:0]         rd_vol_r,
    output logic               tx_valid,
    output logic [BYTE_W-1:0]  tx_data,
    input  logic               tx_ready
);
    import csw_pkg::*;

    localparam int CMD_W   = IDX_W + VAL_W;
    localparam int PTR_W   = $clog2(QDEPTH + 1);
    localparam int QSEL_W  = $clog2(QDEPTH);
    localparam int SEL_W   = $clog2(NUM_REGS);
    localparam int NCH     = 2;
    localparam logic [CODE_W-1:0] DAC_OFF = CODE_W'(DAC_FS - VOL_STEPS);
    localparam logic [CODE_W-1:0] ADC_OFF = CODE_W'(ADC_FS - VOL_STEPS);

    typedef struct packed {
        logic [QDEPTH-1:0][CMD_W-1:0] cmd;
        logic [PTR_W-1:0]             cnt;
        logic [PTR_W-1:0]             ptr;
        logic                         resp_valid;
        logic                         resp_changed;
        logic                         resp_rejected;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_REGS-1:0][DATA_W-1:0] shadow;
    logic                we_a, we_b;
    logic [IDX_W-1:0]    idx_a, idx_b;
    logic [DATA_W-1:0]   dat_a, dat_b;
    logic                word_valid, word_ready, tx_busy, pending, accept;
    logic [NCH-1:0][CODE_W-1:0] dac_codes, adc_codes, vol_rd;
    logic [NCH-1:0][CODE_W-1:0] vol_in;

    function automatic logic [CMD_W-1:0] mk_cmd(
        input logic [IDX_W-1:0] idx,
        input logic [VAL_W-1:0] val
    );
        return {idx, val};
    endfunction

    assign pending    = (ctl_q.ptr != ctl_q.cnt);
    assign busy       = pending || tx_busy;
    assign accept     = req_valid && !busy;
    assign word_valid = pending;
    assign vol_in     = {req_vol_r, req_vol_l};

    always_comb begin
        logic [PTR_W-1:0]   n;
        logic               is_dac;
        logic [CODE_W-1:0]  offs;
        logic [CODE_W-1:0]  code;
        logic [CODE_W-1:0]  cur;
        logic [IDX_W-1:0]   idx_c;

        ctl_d               = ctl_q;
        ctl_d.resp_valid    = 1'b0;
        ctl_d.resp_changed  = 1'b0;
        ctl_d.resp_rejected = 1'b0;
        we_a  = 1'b0; idx_a = '0; dat_a = '0;
        we_b  = 1'b0; idx_b = '0; dat_b = '0;
        n      = '0;
        is_dac = (op_e'(req_op) == OP_VOL_DAC);
        offs   = is_dac ? DAC_OFF : ADC_OFF;
        code   = '0;
        cur    = '0;
        idx_c  = '0;

        if (word_valid && word_ready) ctl_d.ptr = ctl_q.ptr + 1'b1;

        if (accept) begin
            ctl_d.ptr        = '0;
            ctl_d.cnt        = '0;
            ctl_d.resp_valid = 1'b1;
            case (op_e'(req_op))
                OP_WRITE, OP_WRITE_NC: begin
                    if (req_index >= IDX_W'(NUM_REGS) || req_value[DATA_W]) begin
                        ctl_d.resp_rejected = 1'b1;
                    end else begin
                        ctl_d.cmd[0]       = mk_cmd(req_index, req_value[VAL_W-1:0]);
                        ctl_d.cnt          = PTR_W'(1);
                        ctl_d.resp_changed = 1'b1;
                        if (op_e'(req_op) == OP_WRITE) begin
                            we_a  = 1'b1;
                            idx_a = req_index;
                            dat_a = req_value[DATA_W-1:0];
                        end
                    end
                end
                default: begin
                    if (req_vol_l > 8'(VOL_STEPS) || req_vol_r > 8'(VOL_STEPS)) begin
                        ctl_d.resp_rejected = 1'b1;
                    end else begin
                        for (int ch = 0; ch < NCH; ch++) begin
                            code  = vol_to_code(vol_in[ch], offs);
                            cur   = is_dac ? dac_codes[ch] : adc_codes[ch];
                            idx_c = is_dac ? IDX_W'(DAC_BASE + ch) : IDX_W'(ADC_BASE + ch);
                            if (cur != code) begin
                                ctl_d.resp_changed = 1'b1;
                                if (ch == 0) begin
                                    we_a = 1'b1; idx_a = idx_c; dat_a = DATA_W'(code);
                                end else begin
                                    we_b = 1'b1; idx_b = idx_c; dat_b = DATA_W'(code);
                                end
                                ctl_d.cmd[n[QSEL_W-1:0]] = mk_cmd(idx_c, {1'b0, code});
                                n = n + 1'b1;
                                if (is_dac) begin
                                    ctl_d.cmd[n[QSEL_W-1:0]] = mk_cmd(idx_c, {1'b1, code});
                                    n = n + 1'b1;
                                end
                            end
                        end
                        ctl_d.cnt = n;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    csw_shadow #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .DATA_W   (DATA_W)
    ) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_a   (we_a),
        .idx_a  (idx_a),
        .dat_a  (dat_a),
        .we_b   (we_b),
        .idx_b  (idx_b),
        .dat_b  (dat_b),
        .regs_o (shadow)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_codes
        assign dac_codes[ch] = shadow[DAC_BASE + ch][CODE_W-1:0];
        assign adc_codes[ch] = shadow[ADC_BASE + ch][CODE_W-1:0];
    end

    csw_vol_read #(
        .NCH     (NCH),
        .CODE_W  (CODE_W),
        .DAC_OFF (DAC_FS - VOL_STEPS),
        .ADC_OFF (ADC_FS - VOL_STEPS)
    ) u_vol_read (
        .dac_codes_i (dac_codes),
        .adc_codes_i (adc_codes),
        .sel_adc_i   (rd_vol_sel),
        .vol_o       (vol_rd)
    );

    csw_byte_tx #(
        .WORD_W (CMD_W),
        .BYTE_W (BYTE_W)
    ) u_byte_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_valid_i (word_valid),
        .word_i       (ctl_q.cmd[ctl_q.ptr[QSEL_W-1:0]]),
        .word_ready_o (word_ready),
        .tx_valid_o   (tx_valid),
        .tx_data_o    (tx_data),
        .tx_ready_i   (tx_ready),
        .busy_o       (tx_busy)
    );

    assign rd_data       = (rd_index < IDX_W'(NUM_REGS)) ? shadow[rd_index[SEL_W-1:0]] : '0;
    assign rd_vol_l      = vol_rd[0];
    assign rd_vol_r      = vol_rd[1];
    assign resp_valid    = ctl_q.resp_valid;
    assign resp_changed  = ctl_q.resp_changed;
    assign resp_rejected = ctl_q.resp_rejected;

endmodule

// File: rtl/csw_chk.sv
module csw_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic resp_valid,
    input logic resp_changed,
    input logic resp_rejected,
    input logic tx_valid,
    input logic [7:0] tx_data,
    input logic tx_ready
);

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R2
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_rejected |-> !busy && !tx_valid);

    // R8
    no_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_changed |-> !busy);

    // R10
    busy_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !resp_valid);

    // R10
    tx_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    // R8
    change_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_changed |-> busy);

endmodule

bind codec_shadow_writer csw_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .resp_valid    (resp_valid),
    .resp_changed  (resp_changed),
    .resp_rejected (resp_rejected),
    .tx_valid      (tx_valid),
    .tx_data       (tx_data),
    .tx_ready      (tx_ready)
);

// File: tb/codec_shadow_writer_bench.sv
module codec_shadow_writer_bench;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [6:0]  req_index = '0;
    logic [16:0] req_value = '0;
    logic [7:0]  req_vol_l = '0, req_vol_r = '0;
    logic        busy, resp_valid, resp_changed, resp_rejected;
    logic [6:0]  rd_index = '0;
    logic [15:0] rd_data;
    logic        rd_vol_sel = 1'b0;
    logic [7:0]  rd_vol_l, rd_vol_r;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    codec_shadow_writer u_codec_shadow_writer (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_cmd(input logic [6:0] idx, input logic [8:0] val);
        logic [15:0] w;
        w = {idx, val};
        exp_q.push_back(w[15:8]);
        exp_q.push_back(w[7:0]);
    endtask

    task automatic do_req(input logic [1:0] op, input logic [6:0] idx, input logic [16:0] val,
                          input logic [7:0] vl, input logic [7:0] vr,
                          input bit exp_chg, input bit exp_rej, input string req);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_op = op; req_index = idx; req_value = val; req_vol_l = vl; req_vol_r = vr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid === 1'b1, req, "resp_valid", 32'(resp_valid), 1);
        chk(resp_changed === exp_chg, req, "resp_changed", 32'(resp_changed), 32'(exp_chg));
        chk(resp_rejected === exp_rej, req, "resp_rejected", 32'(resp_rejected), 32'(exp_rej));
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic chk_reg(input logic [6:0] idx, input logic [15:0] exp, input string req);
        rd_index = idx;
        #1;
        chk(rd_data === exp, req, $sformatf("rd_data[%0h]", idx), 32'(rd_data), 32'(exp));
    endtask

    task automatic chk_vol(input bit adc, input logic [7:0] el, input logic [7:0] er, input string req);
        rd_vol_sel = adc;
        #1;
        chk(rd_vol_l === el, req, "rd_vol_l", 32'(rd_vol_l), 32'(el));
        chk(rd_vol_r === er, req, "rd_vol_r", 32'(rd_vol_r), 32'(er));
    endtask

    // link stall pattern and byte scoreboard monitor
    initial begin
        int cyc = 0;
        bit held = 1'b0;
        logic [7:0] held_data = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (held) begin
                    // R11 byte must persist through a stall
                    chk(tx_valid === 1'b1 && tx_data === held_data, "R11", "held byte",
                        32'({tx_valid, tx_data}), 32'({1'b1, held_data}));
                end
                cyc++;
                tx_ready = (cyc % 3) != 1;
                if (tx_valid && tx_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R1", "unexpected byte", 32'(tx_data), 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(tx_data === e, "R1", "link byte", 32'(tx_data), 32'(e));
                    end
                end
                held = tx_valid && !tx_ready;
                held_data = tx_data;
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(busy === 1'b0, "R9", "busy after reset", 32'(busy), 0);
        chk(tx_valid === 1'b0, "R9", "tx_valid after reset", 32'(tx_valid), 0);
        chk_reg(7'h00, 16'h0000, "R9");
        chk_reg(7'h17, 16'h0000, "R9");
        chk_vol(1'b0, 8'd0, 8'd0, "R9");

        // R1 R3 cached write
        push_cmd(7'h05, 9'h1A5);
        do_req(2'd0, 7'h05, 17'h001A5, 0, 0, 1'b1, 1'b0, "R3");
        chk_reg(7'h05, 16'h01A5, "R3");
        wait_idle();

        // R3 uncached write leaves shadow
        push_cmd(7'h05, 9'h033);
        do_req(2'd1, 7'h05, 17'h00033, 0, 0, 1'b1, 1'b0, "R3");
        chk_reg(7'h05, 16'h01A5, "R3");
        wait_idle();

        // R2 refusals
        do_req(2'd0, 7'h18, 17'h00001, 0, 0, 1'b0, 1'b1, "R2");
        chk_reg(7'h18, 16'h0000, "R2");
        do_req(2'd0, 7'h02, 17'h10000, 0, 0, 1'b0, 1'b1, "R2");
        chk_reg(7'h02, 16'h0000, "R2");
        do_req(2'd2, 7'h00, 17'h0, 8'd129, 8'd5, 1'b0, 1'b1, "R2");
        chk_vol(1'b0, 8'd0, 8'd0, "R2");

        // R2 boundary accepted
        push_cmd(7'h17, 9'h1FF);
        do_req(2'd0, 7'h17, 17'h0FFFF, 0, 0, 1'b1, 1'b0, "R2");
        chk_reg(7'h17, 16'hFFFF, "R2");
        wait_idle();

        // R4 R6 R7 DAC volume, full scale and one step
        push_cmd(7'h03, 9'h0FF); push_cmd(7'h03, 9'h1FF);
        push_cmd(7'h04, 9'h080); push_cmd(7'h04, 9'h180);
        do_req(2'd2, 0, 0, 8'd128, 8'd1, 1'b1, 1'b0, "R7");
        chk_reg(7'h03, 16'h00FF, "R4");
        chk_reg(7'h04, 16'h0080, "R6");
        chk_vol(1'b0, 8'd128, 8'd1, "R5");
        wait_idle();

        // R8 unchanged volume sends nothing
        do_req(2'd2, 0, 0, 8'd128, 8'd1, 1'b0, 1'b0, "R8");
        chk(busy === 1'b0, "R8", "busy after no-change", 32'(busy), 0);

        // R8 R4 only right channel changes, to mute floor
        push_cmd(7'h04, 9'h000); push_cmd(7'h04, 9'h100);
        do_req(2'd2, 0, 0, 8'd128, 8'd0, 1'b1, 1'b0, "R8");
        chk_reg(7'h04, 16'h0000, "R4");
        wait_idle();

        // R7 ADC volume: cached only
        push_cmd(7'h0E, 9'h08F); push_cmd(7'h0F, 9'h0CF);
        do_req(2'd3, 0, 0, 8'd64, 8'd128, 1'b1, 1'b0, "R7");
        chk_vol(1'b1, 8'd64, 8'd128, "R5");
        chk_reg(7'h0F, 16'h00CF, "R6");
        wait_idle();

        // R5 read-back floor and low-byte use
        push_cmd(7'h03, 9'h050);
        do_req(2'd0, 7'h03, 17'h00050, 0, 0, 1'b1, 1'b0, "R5");
        push_cmd(7'h0E, 9'h050);
        do_req(2'd0, 7'h0E, 17'h01250, 0, 0, 1'b1, 1'b0, "R5");
        wait_idle();
        chk_vol(1'b0, 8'd0, 8'd0, "R5");
        chk_vol(1'b1, 8'd1, 8'd128, "R5");

        // R10 request during busy is ignored
        push_cmd(7'h03, 9'h089); push_cmd(7'h03, 9'h189);
        push_cmd(7'h04, 9'h093); push_cmd(7'h04, 9'h193);
        do_req(2'd2, 0, 0, 8'd10, 8'd20, 1'b1, 1'b0, "R10");
        chk(busy === 1'b1, "R10", "busy while sending", 32'(busy), 1);
        req_op = 2'd0; req_index = 7'h00; req_value = 17'h00001; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid === 1'b0, "R10", "no response while busy", 32'(resp_valid), 0);
        wait_idle();
        chk_reg(7'h00, 16'h0000, "R10");
        chk_vol(1'b0, 8'd10, 8'd20, "R10");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "bytes outstanding", 32'(exp_q.size()), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule